// File: doc/BRIEF.md
# Direct Digital Synthesis Waveform Core

This block is the numeric heart of a direct digital synthesizer. A wide phase register adds a frequency tuning word on every enabled clock. The top bits of that phase, shifted by a programmable phase offset, address an amplitude function. The function returns a sine or cosine sample as an unsigned offset-binary code for a digital-to-analog converter.

The tuning word and the phase offset are staged. Writing to the input ports alone does nothing; an update strobe copies them into the working registers. The same strobe can also zero the phase register. Two overrides are available. One forces a constant full-scale code in place of the waveform. The other freezes the whole datapath to save power.

The amplitude function uses a quarter-wave table with symmetry folding by default. A parameter can select a full-wave table instead. Both tables are computed at elaboration from a fixed-point series.

Top module: `dds_core`

## Requirements
- R1: While `rst_n` is low and afterwards until new data is loaded, the phase register is zero, the working tuning word and offset are zero, and `sample` is 512 (mid-scale).
- R2: On every enabled clock edge the phase register increases by the working tuning word, modulo 2^32. The phase index is bits 31:20 of that register plus the working 12-bit offset, modulo 4096.
- R3: `ftw_in` and `pofs_in` have no effect until `io_update` is high at an enabled edge. That edge copies them into the working registers, and the phase step taken at that edge still uses the old tuning word.
- R4: With `sel_sine` = 1 the amplitude function is a sine of the phase index. With `sel_sine` = 0 it is a cosine, computed as a sine of the index plus 1024.
- R5: For index p, the waveform code is 512 + round(511·sin(2π(p+0.5)/4096)), to within one LSB. It always lies in 1..1023.
- R6: When `io_update` and `autoclr_phase` are both high at an enabled edge, the phase register becomes zero at that edge instead of stepping.
- R7: When `dc_out` is high, the resulting sample is 1023 (all ones) in place of the waveform.
- R8: While `pwr_down` is high, every register holds its value, including `sample`. `io_update` is ignored.
- R9: The output register is updated at the third enabled edge after the phase register, offset, `sel_sine` and `dc_out` are sampled. This latency is the same in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ftw_in | input | 32 | Staged frequency tuning word |
| pofs_in | input | 12 | Staged phase offset |
| io_update | input | 1 | Strobe that loads the staged values |
| autoclr_phase | input | 1 | Zero the phase register on the strobe |
| sel_sine | input | 1 | 1 = sine, 0 = cosine |
| dc_out | input | 1 | Force full-scale constant output |
| pwr_down | input | 1 | Freeze all state |
| sample | output | 10 | Offset-binary amplitude code |

## Verification
The phase register and the working registers change at the edge where the strobe is seen. The output code for a given phase, offset, select and DC choice appears after the third enabled edge that follows. Frozen cycles do not count toward that delay. The bench keeps a two-entry queue of pending samples that advances only on enabled edges and is primed with two mid-scale entries at reset. It compares the design's output against the head of that queue at every falling edge. This gives the exact sample due at each cycle, under every mode change and across frozen stretches.

// File: rtl/dds_pkg.sv
package dds_pkg;

   // pi in Q28 fixed point
   localparam longint PI_Q28 = 64'sd843314857;

   // Magnitude of entry k of a quarter wave with 2**qbits entries,
   // sampled at (k + 0.5) steps, scaled to peak and rounded.
   function automatic int quarter_mag(input int k, input int qbits, input int peak);
      longint x, term, acc;
      x    = ((2 * longint'(k) + 1) * PI_Q28) >>> (qbits + 2);
      term = x;
      acc  = x;
      for (int n = 1; n <= 6; n++) begin
         term = -((((term * x) >>> 28) * x) >>> 28) / longint'((2 * n) * (2 * n + 1));
         acc  = acc + term;
      end
      return int'((acc * longint'(peak) + (64'sd1 <<< 27)) >>> 28);
   endfunction

endpackage

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
   parameter int PHASE_W = 32,
   parameter int ADDR_W  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [PHASE_W-1:0] ftw_in,
   input  logic [ADDR_W-1:0] pofs_in,
   input  logic              load,
   input  logic              clr_on_load,
   output logic [ADDR_W-1:0] phase_top,
   output logic [ADDR_W-1:0] pofs_act
);

   logic [PHASE_W-1:0] acc;
   logic [PHASE_W-1:0] ftw_act;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc      <= '0;
         ftw_act  <= '0;
         pofs_act <= '0;
      end else if (en) begin
         if (load && clr_on_load) acc <= '0;
         else                     acc <= acc + ftw_act;
         if (load) begin
            ftw_act  <= ftw_in;
            pofs_act <= pofs_in;
         end
      end
   end

   assign phase_top = acc[PHASE_W-1 -: ADDR_W];

   a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !(load && clr_on_load)) |=> acc == $past(acc) + $past(ftw_act));

   a_r6_autoclear: assert property (@(posedge clk) disable iff (!rst_n)
      (en && load && clr_on_load) |=> acc == '0);

   a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
      (en && load) |=> (ftw_act == $past(ftw_in)) && (pofs_act == $past(pofs_in)));

   a_r8_acc_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(acc) && $stable(ftw_act) && $stable(pofs_act));

endmodule

// File: rtl/dds_sine_lut.sv
module dds_sine_lut
   import dds_pkg::*;
#(
   parameter int ADDR_W  = 12,
   parameter int AMP_W   = 10,
   parameter bit QUARTER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [ADDR_W-1:0] ph_idx,
   output logic [AMP_W-2:0]  mag_q,
   output logic              neg_q
);

   localparam int QBITS = ADDR_W - 2;
   localparam int PEAK  = (1 << (AMP_W - 1)) - 1;

   logic [AMP_W-2:0] mag_d;
   logic             neg_d;

   generate
      if (QUARTER) begin : g_quarter
         logic [AMP_W-2:0] tbl [2**QBITS];
         logic [QBITS-1:0] k;
         for (genvar i = 0; i < 2**QBITS; i++) begin : g_ent
            assign tbl[i] = (AMP_W-1)'(quarter_mag(i, QBITS, PEAK));
         end
         assign k     = ph_idx[ADDR_W-2] ? ~ph_idx[QBITS-1:0] : ph_idx[QBITS-1:0];
         assign mag_d = tbl[k];
         assign neg_d = ph_idx[ADDR_W-1];
      end else begin : g_full
         logic [AMP_W-1:0] tbl [2**ADDR_W];
         for (genvar i = 0; i < 2**ADDR_W; i++) begin : g_ent
            localparam int QD = i >> QBITS;
            localparam int KK = i % (2**QBITS);
            localparam int KF = (QD % 2 == 1) ? (2**QBITS - 1 - KK) : KK;
            assign tbl[i] = {QD >= 2, (AMP_W-1)'(quarter_mag(KF, QBITS, PEAK))};
         end
         assign mag_d = tbl[ph_idx][AMP_W-2:0];
         assign neg_d = tbl[ph_idx][AMP_W-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mag_q <= '0;
         neg_q <= 1'b0;
      end else if (en) begin
         mag_q <= mag_d;
         neg_q <= neg_d;
      end
   end

   a_r8_lut_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(mag_q) && $stable(neg_q));

endmodule

// File: rtl/dds_core.sv
module dds_core #(
   parameter int PHASE_W = 32,
   parameter int ADDR_W  = 12,
   parameter int AMP_W   = 10,
   parameter bit QUARTER = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [PHASE_W-1:0] ftw_in,
   input  logic [ADDR_W-1:0]  pofs_in,
   input  logic               io_update,
   input  logic               autoclr_phase,
   input  logic               sel_sine,
   input  logic               dc_out,
   input  logic               pwr_down,
   output logic [AMP_W-1:0]   sample
);

   localparam logic [ADDR_W-1:0] QTR_TURN = ADDR_W'(1 << (ADDR_W - 2));
   localparam logic [AMP_W-1:0]  MID      = AMP_W'(1 << (AMP_W - 1));

   generate
      if (PHASE_W < ADDR_W) begin : g_bad_phase
         $error("dds_core: PHASE_W must be at least ADDR_W");
      end
      if (ADDR_W < 3 || ADDR_W > 14) begin : g_bad_addr
         $error("dds_core: ADDR_W must lie in 3..14");
      end
      if (AMP_W < 2 || AMP_W > 16) begin : g_bad_amp
         $error("dds_core: AMP_W must lie in 2..16");
      end
   endgenerate

   logic              en;
   logic [ADDR_W-1:0] phase_top;
   logic [ADDR_W-1:0] pofs_act;
   logic [ADDR_W-1:0] idx_q;
   logic              dc_p1, dc_p2;
   logic [AMP_W-2:0]  mag_q;
   logic              neg_q;

   assign en = ~pwr_down;

   dds_phase_acc #(.PHASE_W(PHASE_W), .ADDR_W(ADDR_W)) u_acc (
      .clk         (clk),
      .rst_n       (rst_n),
      .en          (en),
      .ftw_in      (ftw_in),
      .pofs_in     (pofs_in),
      .load        (io_update),
      .clr_on_load (autoclr_phase),
      .phase_top   (phase_top),
      .pofs_act    (pofs_act)
   );

   // stage 1: phase index with offset and sine/cosine rotation
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
         dc_p1 <= 1'b0;
      end else if (en) begin
         idx_q <= phase_top + pofs_act + (sel_sine ? '0 : QTR_TURN);
         dc_p1 <= dc_out;
      end
   end

   // stage 2: amplitude lookup
   dds_sine_lut #(.ADDR_W(ADDR_W), .AMP_W(AMP_W), .QUARTER(QUARTER)) u_lut (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (en),
      .ph_idx (idx_q),
      .mag_q  (mag_q),
      .neg_q  (neg_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  dc_p2 <= 1'b0;
      else if (en) dc_p2 <= dc_p1;
   end

   // stage 3: offset-binary output with DC override
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sample <= MID;
      end else if (en) begin
         if (dc_p2)      sample <= '1;
         else if (neg_q) sample <= MID - {1'b0, mag_q};
         else            sample <= {1'b1, mag_q};
      end
   end

   a_r7_dc_full: assert property (@(posedge clk) disable iff (!rst_n)
      (en && dc_p2) |=> sample == '1);

   a_r8_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(sample));

   a_r5_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
      sample != '0);

   a_r4_cos_turn: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !sel_sine) |=> idx_q == $past(phase_top) + $past(pofs_act) + QTR_TURN);

endmodule

// File: tb/dds_core_bench.sv
module dds_core_bench;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] ftw_in = '0;
   logic [11:0] pofs_in = '0;
   logic        io_update = 1'b0;
   logic        autoclr_phase = 1'b0;
   logic        sel_sine = 1'b1;
   logic        dc_out = 1'b0;
   logic        pwr_down = 1'b0;
   logic [9:0]  sample;

   int    n_checks = 0;
   int    n_fail   = 0;
   string cur_req  = "R1";
   bit    done     = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   dds_core u_dds_core (
      .clk(clk), .rst_n(rst_n), .ftw_in(ftw_in), .pofs_in(pofs_in),
      .io_update(io_update), .autoclr_phase(autoclr_phase), .sel_sine(sel_sine),
      .dc_out(dc_out), .pwr_down(pwr_down), .sample(sample)
   );

   // behavioural reference
   bit [31:0] acc_m, ftw_m;
   bit [11:0] pofs_m;
   int        pend[$];
   int        exp_s = 512;

   function automatic int wave(input int p);
      real th, s;
      int  m;
      th = 2.0 * 3.14159265358979 * (real'(p) + 0.5) / 4096.0;
      s  = $sin(th);
      m  = $rtoi(511.0 * (s < 0.0 ? -s : s) + 0.5);
      return (s < 0.0) ? 512 - m : 512 + m;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         acc_m = '0; ftw_m = '0; pofs_m = '0;
         pend.delete();
         pend.push_back(0);
         pend.push_back(0);
         exp_s = 512;
      end else if (!pwr_down) begin
         int ix, e;
         ix = (int'(acc_m[31:20]) + int'(pofs_m) + (sel_sine ? 0 : 1024)) % 4096;
         pend.push_back((dc_out ? 4096 : 0) + ix);
         e = pend.pop_front();
         exp_s = (e >= 4096) ? 1023 : wave(e);
         acc_m = (io_update && autoclr_phase) ? 32'd0 : acc_m + ftw_m;
         if (io_update) begin
            ftw_m  = ftw_in;
            pofs_m = pofs_in;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         int d;
         n_checks++;
         d = int'(sample) - exp_s;
         if (d > 1 || d < -1 || sample == 10'd0) begin
            n_fail++;
            $display("FAIL %s: sample=%0d expected=%0d (+-1)", cur_req, sample, exp_s);
         end
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic strobe(input logic [31:0] f, input logic [11:0] o, input logic clr);
      @(negedge clk);
      ftw_in = f; pofs_in = o; autoclr_phase = clr; io_update = 1'b1;
      @(negedge clk);
      io_update = 1'b0; autoclr_phase = 1'b0;
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      cur_req = "R1";  idle(8);                       // reset state, mid-scale
      cur_req = "R2";  strobe(32'h0123_4567, 12'h000, 1'b0); idle(300);
      cur_req = "R3";  ftw_in = 32'h3000_0000; pofs_in = 12'h7FF; idle(20); // staged only
      strobe(32'h0040_0000, 12'h400, 1'b0); idle(100);
      cur_req = "R4";
      for (int i = 0; i < 40; i++) begin sel_sine = ~sel_sine; idle(5); end
      sel_sine = 1'b1;
      cur_req = "R5";  strobe(32'h7FF0_0000, 12'h000, 1'b0); idle(200);
      strobe(32'h0010_0000, 12'h000, 1'b1); idle(4200);  // full sweep of 4096 indices
      cur_req = "R6";  strobe(32'h0200_0000, 12'h123, 1'b1); idle(30);
      strobe(32'h0200_0000, 12'h000, 1'b1); idle(10);
      cur_req = "R7";  dc_out = 1'b1; idle(10); dc_out = 1'b0; idle(10);
      cur_req = "R8";  pwr_down = 1'b1;
      ftw_in = 32'hDEAD_BEEF; io_update = 1'b1; idle(3); io_update = 1'b0; idle(17);
      pwr_down = 1'b0; idle(20);
      for (int i = 0; i < 30; i++) begin pwr_down = (i % 3 == 0); idle(1); end
      pwr_down = 1'b0;
      cur_req = "R9";
      for (int i = 0; i < 60; i++) begin
         dc_out = (i % 4 == 1); sel_sine = (i % 7 < 3); idle(1);
      end
      dc_out = 1'b0; sel_sine = 1'b1; idle(10);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule